// File: doc/BRIEF.md
# Level-2 Cache Controller Register Stub

This block stands in for the control register window of a level-2 cache controller when no cache is fitted. Software that probes and programs such a controller gets plausible answers: a fixed identification word, a cache type word, and a set of control, RAM-latency and address-filter registers that hold whatever is written to them. Maintenance operations are accepted silently and always report completion. Nothing is cached and no data path exists.

The bus is a single-cycle strobe interface. An access presents an address with a read strobe, a write strobe or both. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read strobe. An access to an offset that is not mapped raises an error pulse in the same cycle. The cache type word is special: each read of it merges bits taken from the auxiliary control register into a stored value. The stored value keeps every bit it has gathered, so bits are never lost after they are set.

Top module: `l2stub_top`

## Requirements
- R1: Only address bits 11:0 select a register; address bits above bit 11 have no effect, so a 4 KiB window repeats.
- R2: A read of offset 0x000 returns 0x410000C8. A write to 0x000 is a bad access and changes no register.
- R3: A write to offset 0x100 (control) stores bit 0 of the write data. Reads of 0x100 return that bit in bit 0, with bits 31:1 zero.
- R4: Offsets 0x104 (auxiliary control), 0x108 (tag RAM control), 0x10C (data RAM control), 0xC00 (filter start) and 0xC04 (filter end) are full 32-bit read/write registers.
- R5: Every offset from 0x730 up to 0x7FF reads as zero, meaning the operation is complete. Writes there are discarded. Neither reads nor writes there raise the error output.
- R6: Offsets 0xF40, 0xF60 and 0xF80 read as zero and discard writes, with no error.
- R7: A read of offset 0x004 forms a 5-bit field: bits 4:2 are auxiliary bits 19:17, bit 1 is zero, and bit 0 is auxiliary bit 16. This field is ORed into the stored type word at bits 22:18 and at bits 10:6. The result is stored and returned. The stored word starts at 0x1C100100 and never loses a set bit. A write to 0x004 is a bad access and changes nothing.
- R8: After reset, control, tag control, data control and both filter registers read 0, and auxiliary control reads 0x02020000.
- R9: A read of an unmapped offset returns zero, and a write to one changes no register. bus_err is high in the same cycle as any such access, and it is also high for a write to 0x000 or 0x004. bus_err is low otherwise.
- R10: bus_rdata is registered. It carries the read result in the cycle after bus_rd, and it is zero in the cycle after a cycle without bus_rd.
- R11: When bus_rd and bus_wr are both high, the write takes effect and bus_rdata returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (32) | Byte address; only bits 11:0 are decoded |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_err | output | 1 | High in the cycle of an access to an unmapped or read-only offset |

## Verification
The assertions check on every cycle that the identification word and the zero completion status come back after their reads, that control reads never show bits above bit 0, and that the error pulse never appears without a strobe. They also check that the type word only gains bits and holds still when it is not read, and that the read data falls back to zero after an idle cycle. The bench scenarios are the only way to show the exact merge of auxiliary bits into the type word, and that this merge stays after the auxiliary register is cleared. The same holds for aliasing through the upper address bits, the old-value return when a read and a write happen together, and the error and silent-discard split across the edges of the maintenance range and the three fixed offsets.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;

   // Register selector produced by the offset decoder.
   typedef enum logic [3:0] {
      SEL_ID,
      SEL_TYPE,
      SEL_CTRL,
      SEL_AUX,
      SEL_TAG,
      SEL_DRAM,
      SEL_FLO,
      SEL_FHI,
      SEL_MAINT,
      SEL_NULL,
      SEL_BAD
   } sel_e;

   localparam int NUM_PLAIN = 5;

   // Plain register index -> selector. Index 0 must stay auxiliary control,
   // because the type word takes its bits from it.
   function automatic sel_e plain_sel(input int idx);
      case (idx)
         0:       return SEL_AUX;
         1:       return SEL_TAG;
         2:       return SEL_DRAM;
         3:       return SEL_FLO;
         default: return SEL_FHI;
      endcase
   endfunction

   // Selectors that may be read without an error.
   function automatic logic sel_readable(input sel_e s);
      return s != SEL_BAD;
   endfunction

   // Selectors that may be written without an error.
   function automatic logic sel_writable(input sel_e s);
      return !(s == SEL_BAD || s == SEL_ID || s == SEL_TYPE);
   endfunction

endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
   import l2stub_pkg::*;
#(
   parameter int                       OFS_W     = 12,
   parameter logic [OFS_W-1:0]         OFS_ID    = 12'h000,
   parameter logic [OFS_W-1:0]         OFS_TYPE  = 12'h004,
   parameter logic [OFS_W-1:0]         OFS_CTRL  = 12'h100,
   parameter logic [OFS_W-1:0]         OFS_AUX   = 12'h104,
   parameter logic [OFS_W-1:0]         OFS_TAG   = 12'h108,
   parameter logic [OFS_W-1:0]         OFS_DRAM  = 12'h10C,
   parameter logic [OFS_W-1:0]         OFS_FLO   = 12'hC00,
   parameter logic [OFS_W-1:0]         OFS_FHI   = 12'hC04,
   parameter logic [OFS_W-1:0]         MAINT_LO  = 12'h730,
   parameter logic [OFS_W:0]           MAINT_END = 13'h0800,
   parameter int                       NULL_CNT  = 3,
   parameter logic [NULL_CNT*OFS_W-1:0] NULL_LIST = {12'hF80, 12'hF60, 12'hF40}
) (
   input  logic [OFS_W-1:0] ofs,
   output sel_e             sel,
   output logic             rd_ok,
   output logic             wr_ok
);

   if (NULL_CNT < 1) begin : g_chk_null
      $error("l2stub_decode: NULL_CNT must be at least 1");
   end
   if ({1'b0, MAINT_LO} >= MAINT_END) begin : g_chk_maint
      $error("l2stub_decode: maintenance range is empty");
   end

   logic [NULL_CNT-1:0] null_hit;
   logic                maint_hit;

   for (genvar g = 0; g < NULL_CNT; g++) begin : g_null
      assign null_hit[g] = (ofs == NULL_LIST[g*OFS_W +: OFS_W]);
   end

   assign maint_hit = (ofs >= MAINT_LO) && ({1'b0, ofs} < MAINT_END);

   always_comb begin
      sel = SEL_BAD;
      if (maint_hit) begin
         sel = SEL_MAINT;
      end else if (|null_hit) begin
         sel = SEL_NULL;
      end else begin
         case (ofs)
            OFS_ID:   sel = SEL_ID;
            OFS_TYPE: sel = SEL_TYPE;
            OFS_CTRL: sel = SEL_CTRL;
            OFS_AUX:  sel = SEL_AUX;
            OFS_TAG:  sel = SEL_TAG;
            OFS_DRAM: sel = SEL_DRAM;
            OFS_FLO:  sel = SEL_FLO;
            OFS_FHI:  sel = SEL_FHI;
            default:  sel = SEL_BAD;
         endcase
      end
   end

   assign rd_ok = sel_readable(sel);
   assign wr_ok = sel_writable(sel);

   // R5: every offset inside the maintenance range is accepted both ways
   always_comb begin
      a_r5_maint_ok : assert (!maint_hit || (rd_ok && wr_ok))
         else $error("maintenance offset not accepted");
   end

endmodule

// File: rtl/l2stub_regbank.sv
module l2stub_regbank
   import l2stub_pkg::*;
#(
   parameter int                            DATA_W     = 32,
   parameter int                            CTRL_W     = 1,
   parameter int                            PLAIN_N    = NUM_PLAIN,
   parameter logic [PLAIN_N*DATA_W-1:0]     PLAIN_INIT = {32'h0, 32'h0, 32'h0, 32'h0, 32'h02020000}
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  sel_e                            sel,
   input  logic [DATA_W-1:0]               wdata,
   output logic [DATA_W-1:0]               ctrl_q,
   output logic [PLAIN_N-1:0][DATA_W-1:0]  plain_q
);

   if (CTRL_W < 1 || CTRL_W > DATA_W) begin : g_chk_ctrl
      $error("l2stub_regbank: CTRL_W out of range");
   end
   if (PLAIN_N != NUM_PLAIN) begin : g_chk_plain
      $error("l2stub_regbank: PLAIN_N must match the package");
   end

   logic [CTRL_W-1:0] ctrl_bits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_bits <= '0;
      end else if (wr_en && sel == SEL_CTRL) begin
         ctrl_bits <= wdata[CTRL_W-1:0];
      end
   end

   if (CTRL_W == DATA_W) begin : g_ctrl_full
      assign ctrl_q = ctrl_bits;
   end else begin : g_ctrl_pad
      assign ctrl_q = {{(DATA_W-CTRL_W){1'b0}}, ctrl_bits};
   end

   for (genvar g = 0; g < PLAIN_N; g++) begin : g_plain
      localparam sel_e MY_SEL = plain_sel(g);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            plain_q[g] <= PLAIN_INIT[g*DATA_W +: DATA_W];
         end else if (wr_en && sel == MY_SEL) begin
            plain_q[g] <= wdata;
         end
      end

      // R4: a register not addressed by a write keeps its value
      a_r4_plain_hold : assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && sel == MY_SEL) |=> $stable(plain_q[g]))
         else $error("plain register changed without a write");
   end

   // R3: a control write keeps exactly bit 0 of the data
   a_r3_ctrl_keep : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CTRL) |=> (ctrl_q == DATA_W'($past(wdata[0]))))
      else $error("control register did not keep bit 0");

endmodule

// File: rtl/l2stub_typeword.sv
module l2stub_typeword #(
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] TYPE_INIT = 32'h1C100100,
   parameter int                FIELD_W   = 5,
   parameter int                LANE_HI   = 18,
   parameter int                LANE_LO   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hit,
   input  logic [3:0]        aux_bits,
   output logic [DATA_W-1:0] type_next
);

   localparam int LANES = 2;

   if (FIELD_W != 5) begin : g_chk_field
      $error("l2stub_typeword: field is built from five bits");
   end
   if (LANE_HI + FIELD_W > DATA_W || LANE_LO + FIELD_W > LANE_HI) begin : g_chk_lane
      $error("l2stub_typeword: lanes overlap or overflow the word");
   end

   logic [FIELD_W-1:0]           field;
   logic [LANES-1:0][DATA_W-1:0] lane_vec;
   logic [DATA_W-1:0]            merge_mask;
   logic [DATA_W-1:0]            type_q;

   // aux_bits[3:1] are auxiliary bits 19:17, aux_bits[0] is auxiliary bit 16
   assign field = {aux_bits[3:1], 1'b0, aux_bits[0]};

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int POS = (g == 0) ? LANE_HI : LANE_LO;
      assign lane_vec[g] = {{(DATA_W-FIELD_W){1'b0}}, field} << POS;
   end

   assign merge_mask = lane_vec[0] | lane_vec[1];
   assign type_next  = type_q | merge_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         type_q <= TYPE_INIT;
      end else if (rd_hit) begin
         type_q <= type_next;
      end
   end

   // R7: the stored type word never loses a bit
   a_r7_type_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      ((type_q & $past(type_q)) == $past(type_q)))
      else $error("type word lost a bit");

   // R7: the stored type word only moves on a read of it
   a_r7_type_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> $stable(type_q))
      else $error("type word changed without a read");

endmodule

// File: rtl/l2stub_top.sv
module l2stub_top
   import l2stub_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] ID_WORD   = 32'h410000C8,
   parameter logic [DATA_W-1:0] TYPE_INIT = 32'h1C100100,
   parameter logic [DATA_W-1:0] AUX_INIT  = 32'h02020000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err
);

   localparam int OFS_W = 12;

   if (DATA_W < 24) begin : g_chk_data
      $error("l2stub_top: DATA_W must hold the type word lanes");
   end
   if (ADDR_W < OFS_W) begin : g_chk_addr
      $error("l2stub_top: ADDR_W narrower than the window");
   end

   logic [OFS_W-1:0]                 ofs;
   sel_e                             sel;
   logic                             rd_ok;
   logic                             wr_ok;
   logic                             wr_en;
   logic [DATA_W-1:0]                ctrl_q;
   logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q;
   logic [DATA_W-1:0]                type_next;
   logic [DATA_W-1:0]                rd_mux;
   logic [DATA_W-1:0]                rdata_q;

   assign ofs = bus_addr[OFS_W-1:0];

   if (ADDR_W > OFS_W) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFS_W];
   end

   l2stub_decode #(.OFS_W(OFS_W)) u_decode (
      .ofs   (ofs),
      .sel   (sel),
      .rd_ok (rd_ok),
      .wr_ok (wr_ok)
   );

   assign wr_en = bus_wr && wr_ok;

   l2stub_regbank #(
      .DATA_W     (DATA_W),
      .CTRL_W     (1),
      .PLAIN_N    (NUM_PLAIN),
      .PLAIN_INIT ({{(4*DATA_W){1'b0}}, AUX_INIT})
   ) u_regbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .sel     (sel),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_q),
      .plain_q (plain_q)
   );

   l2stub_typeword #(
      .DATA_W    (DATA_W),
      .TYPE_INIT (TYPE_INIT)
   ) u_typeword (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_hit    (bus_rd && sel == SEL_TYPE),
      .aux_bits  (plain_q[0][19:16]),
      .type_next (type_next)
   );

   always_comb begin
      case (sel)
         SEL_ID:   rd_mux = ID_WORD;
         SEL_TYPE: rd_mux = type_next;
         SEL_CTRL: rd_mux = ctrl_q;
         SEL_AUX:  rd_mux = plain_q[0];
         SEL_TAG:  rd_mux = plain_q[1];
         SEL_DRAM: rd_mux = plain_q[2];
         SEL_FLO:  rd_mux = plain_q[3];
         SEL_FHI:  rd_mux = plain_q[4];
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_rd) begin
         rdata_q <= rd_mux;
      end else begin
         rdata_q <= '0;
      end
   end

   assign bus_rdata = rdata_q;
   assign bus_err   = (bus_rd && !rd_ok) || (bus_wr && !wr_ok);

   // R2: identification read returns the fixed word
   a_r2_id_word : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ofs == 12'h000) |=> (bus_rdata == ID_WORD))
      else $error("identification word wrong");

   // R5: maintenance range reads complete (zero)
   a_r5_maint_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ofs >= 12'h730 && ofs < 12'h800) |=> (bus_rdata == '0))
      else $error("maintenance read not zero");

   // R3: control reads never show upper bits
   a_r3_ctrl_upper : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ofs == 12'h100) |=> (bus_rdata[DATA_W-1:1] == '0))
      else $error("control read shows upper bits");

   // R9: no error pulse without a strobe
   a_r9_err_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rd || bus_wr))
      else $error("error without access");

   // R10: read data is zero after a cycle without a read
   a_r10_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0))
      else $error("read data not zero after idle");

   // R11: read with write on auxiliary control returns the old value
   a_r11_rw_old : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_wr && ofs == 12'h104) |=> (bus_rdata == $past(plain_q[0])))
      else $error("simultaneous access returned new value");

endmodule

// File: tb/l2stub_top_tb.sv
module l2stub_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   l2stub_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_ctrl, m_aux, m_tag, m_dram, m_flo, m_fhi, m_type;

   task automatic m_reset();
      m_ctrl = 0; m_aux = 32'h02020000; m_tag = 0; m_dram = 0;
      m_flo = 0; m_fhi = 0; m_type = 32'h1C100100;
   endtask

   function automatic bit m_zero_slot(input int o);
      return (o >= 'h730 && o < 'h800) || o == 'hF40 || o == 'hF60 || o == 'hF80;
   endfunction

   function automatic bit m_wr_ok(input int o);
      return m_zero_slot(o) || o == 'h100 || o == 'h104 || o == 'h108 ||
             o == 'h10C || o == 'hC00 || o == 'hC04;
   endfunction

   function automatic bit m_rd_ok(input int o);
      return m_wr_ok(o) || o == 'h000 || o == 'h004;
   endfunction

   task automatic m_read(input int o, output logic [31:0] v);
      int f;
      v = 0;
      case (o)
         'h000: v = 32'h410000C8;
         'h004: begin
            f = ((m_aux >> 17) & 7) * 4 + ((m_aux >> 16) & 1);
            m_type = m_type | (f << 18) | (f << 6);
            v = m_type;
         end
         'h100: v = m_ctrl;
         'h104: v = m_aux;
         'h108: v = m_tag;
         'h10C: v = m_dram;
         'hC00: v = m_flo;
         'hC04: v = m_fhi;
         default: v = 0;
      endcase
   endtask

   task automatic m_write(input int o, input logic [31:0] d);
      case (o)
         'h100: m_ctrl = d & 1;
         'h104: m_aux = d;
         'h108: m_tag = d;
         'h10C: m_dram = d;
         'hC00: m_flo = d;
         'hC04: m_fhi = d;
         default: ;
      endcase
   endtask

   // ---------------- checking ----------------
   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic op(input logic [31:0] a, input bit r, input bit w,
                     input logic [31:0] d, input string tag);
      int o;
      logic [31:0] exp_d;
      bit exp_e;
      o = int'(a[11:0]);
      @(negedge clk);
      bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
      exp_e = (r && !m_rd_ok(o)) || (w && !m_wr_ok(o));
      #1;
      check(tag, "err", {31'b0, bus_err}, {31'b0, exp_e});
      exp_d = 0;
      if (r) m_read(o, exp_d);
      if (w) m_write(o, d);
      @(posedge clk);
      #1;
      bus_rd = 0; bus_wr = 0;
      check(tag, "rdata", bus_rdata, exp_d);
   endtask

   task automatic rd(input logic [31:0] a, input string tag);
      op(a, 1'b1, 1'b0, '0, tag);
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
      op(a, 1'b0, 1'b1, d, tag);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      m_reset();
      repeat (5) @(posedge clk);
      #1 check("R8", "rdata in reset", bus_rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8 / R2 / R7 reset values
      rd(32'h000, "R2");
      rd(32'h004, "R7");
      rd(32'h100, "R8");
      rd(32'h104, "R8");
      rd(32'h108, "R8");
      rd(32'h10C, "R8");
      rd(32'hC00, "R8");
      rd(32'hC04, "R8");

      // R10: idle cycle gives zero
      op(32'h104, 1'b0, 1'b0, '0, "R10");

      // R3 control keeps bit 0
      wr(32'h100, 32'hFFFF_FFFF, "R3");
      rd(32'h100, "R3");
      wr(32'h100, 32'hFFFF_FFFE, "R3");
      rd(32'h100, "R3");

      // R4 full read/write registers, several patterns
      wr(32'h108, 32'hA5A5_5A5A, "R4");
      wr(32'h10C, 32'h1234_5678, "R4");
      wr(32'hC00, 32'hFFFF_0000, "R4");
      wr(32'hC04, 32'h0000_FFFF, "R4");
      rd(32'h108, "R4");
      rd(32'h10C, "R4");
      rd(32'hC00, "R4");
      rd(32'hC04, "R4");

      // R1 aliasing through upper address bits
      wr(32'hABC0_0108, 32'hDEAD_BEEF, "R1");
      rd(32'h0000_0108, "R1");
      rd(32'h7FFF_F000, "R1");

      // R5 maintenance range edges
      wr(32'h730, 32'hFFFF_FFFF, "R5");
      wr(32'h7FC, 32'hFFFF_FFFF, "R5");
      rd(32'h730, "R5");
      rd(32'h7FF, "R5");
      rd(32'h72C, "R9");
      rd(32'h800, "R9");
      rd(32'h10C, "R5");

      // R6 fixed zero offsets
      wr(32'hF40, 32'h1, "R6");
      wr(32'hF60, 32'h1, "R6");
      wr(32'hF80, 32'h1, "R6");
      rd(32'hF40, "R6");
      rd(32'hF60, "R6");
      rd(32'hF80, "R6");
      rd(32'hF44, "R9");

      // R7 type merge and stickiness
      wr(32'h104, 32'h0009_0000, "R7");
      rd(32'h004, "R7");
      wr(32'h104, 32'h0000_0000, "R7");
      rd(32'h004, "R7");
      wr(32'h104, 32'h000E_0000, "R7");
      rd(32'h004, "R7");
      wr(32'h004, 32'hFFFF_FFFF, "R7");
      rd(32'h004, "R7");

      // R9 unmapped and read-only offsets
      rd(32'h200, "R9");
      wr(32'h200, 32'h55, "R9");
      wr(32'h000, 32'h55, "R2");
      rd(32'h000, "R2");
      op(32'h000, 1'b1, 1'b1, 32'h1, "R9");

      // R11 simultaneous read and write
      wr(32'h104, 32'h1111_1111, "R11");
      op(32'h104, 1'b1, 1'b1, 32'h2222_2222, "R11");
      rd(32'h104, "R11");
      op(32'h100, 1'b1, 1'b1, 32'h3, "R11");
      rd(32'h100, "R11");

      // R10 idle after reads
      op(32'h000, 1'b0, 1'b0, '0, "R10");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule